// File: doc/BRIEF.md
# Linear Burst Read Port Controller

This block is the device-side sequencer for a synchronous parallel memory read port. When chip-enable is low, a low address-valid strobe captures a start address. The block then waits a programmable number of clocks and walks the internal array linearly, one word per clock, for a burst of four or eight beats. It registers each word into an output stage that feeds a tri-stated data bus. An end-of-burst marker leaves that stage in step with the data.

A small configuration register sets the behaviour. It enables burst mode, which is off after reset, and sets the initial latency, the burst length and the beat on which the end-of-burst marker appears. Output-enable only floats the data and marker drivers, and the internal burst keeps running while they float. A burst stops early only when chip-enable goes high or a fresh address strobe arrives.

Top module: `lbr_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears any burst at once. While reset is applied, `dvalid`, `dq_oe` and `eob_oe` are low. After reset the configuration is sync=0, lat=3, len8=0 and sel=000, so burst mode is off.
- R2: Configuration word layout: bit 0 = sync, bits 3:1 = lat, bit 4 = len8, bits 7:5 = sel. A write is accepted only if lat is between 2 and 7. A write with lat 0 or 1 leaves the whole register unchanged.
- R3: With sync=0, an address strobe starts nothing: `dvalid` stays low and the indicator is not driven.
- R4: Take the clock edge that samples `adv_n`=0 with `ce_n`=0 as edge k. With latency L, the first beat is presented after edge k+L.
- R5: A burst presents N beats on N consecutive clocks, where N is 4 if len8=0 and 8 if len8=1. Beat i reads array address start+i, with no wrap. `dvalid` is high for exactly those clocks.
- R6: While `oe_n` is high, `dq_oe` and `eob_oe` are low, but the burst keeps advancing. On return of `oe_n`=0, the beat due at that clock is driven.
- R7: With `ce_n` high, `dq_oe` drops at once and `dvalid` is low after the next edge. The burst does not resume.
- R8: A new strobe during a burst restarts it. The new address is captured, `dvalid` is low after that edge, and the new burst has the full latency.
- R9: With sel=001, `eob_n` is low for one clock, on the last beat only.
- R10: With sel=011, `eob_n` is low for one clock, on the second-to-last beat only.
- R11: With any other sel value, `eob_n` stays high on every beat.
- R12: `eob_oe` is high exactly when `oe_n`=0, `ce_n`=0 and sync=1. When driven, `eob_n` is low only on a beat where `dvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; high aborts a burst |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | AW | Start address captured on the strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write word |
| arr_addr | output | AW | Address to the internal array |
| data_in | input | DW | Word read from the array at `arr_addr` |
| dq_out | output | DW | Registered output word |
| dq_oe | output | 1 | Drive enable for the data pads |
| dvalid | output | 1 | A beat is present in the output stage |
| eob_n | output | 1 | End-of-burst marker, active low |
| eob_oe | output | 1 | Drive enable for the marker pad |

## Verification
A latency counter left in the wrong state moves the first beat earlier or later. This shows within one burst as a wrong count of clocks from strobe to the first `dvalid`. A beat counter or base address in the wrong state shows on the next beat, either as a wrong word or as a burst whose length is off by one or more. A stale configuration snapshot moves the marker to the wrong beat. A burst that abort or restart did not clear shows as `dvalid` still high one clock after the terminating edge.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  localparam int BEAT_W = 4;
  localparam int LAT_W  = 3;

  typedef struct packed {
    logic [2:0]       sel;   // indicator placement code
    logic             len8;  // 1: eight beats, 0: four beats
    logic [LAT_W-1:0] lat;   // initial latency in clocks
    logic             sync;  // 1: burst mode enabled
  } lbr_cfg_t;

  localparam lbr_cfg_t CFG_RESET = '{sel: 3'b000, len8: 1'b0, lat: 3'd3, sync: 1'b0};

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_BURST} lbr_state_e;

  function automatic logic cfg_write_ok(input lbr_cfg_t c);
    return c.lat >= LAT_W'(2);
  endfunction

  function automatic logic [BEAT_W-1:0] burst_beats(input lbr_cfg_t c);
    return c.len8 ? BEAT_W'(8) : BEAT_W'(4);
  endfunction

  function automatic logic eob_hit(input lbr_cfg_t c, input logic [BEAT_W-1:0] beat);
    logic [BEAT_W-1:0] n;
    n = burst_beats(c);
    case (c.sel)
      3'b001:  return beat == n - BEAT_W'(1);
      3'b011:  return beat == n - BEAT_W'(2);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lbr_cfg_reg.sv
module lbr_cfg_reg
  import lbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output lbr_cfg_t   cfg
);

  lbr_cfg_t wr_word;
  assign wr_word = lbr_cfg_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (we && cfg_write_ok(wr_word)) begin
      cfg <= wr_word;
    end
  end

endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
  import lbr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lbr_cfg_t      cfg,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] arr_addr,
  output logic          fire,
  output logic          eob_now
);

  lbr_state_e        state_q;
  lbr_cfg_t          act_q;     // configuration frozen at burst start
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [LAT_W-1:0]  lat_q;
  logic              start_w;
  logic              last_w;

  assign start_w  = !ce_n && !adv_n && cfg.sync;
  assign last_w   = beat_q == burst_beats(act_q) - BEAT_W'(1);
  assign fire     = (state_q == ST_BURST) && !ce_n && adv_n;
  assign arr_addr = base_q + AW'(beat_q);
  assign eob_now  = eob_hit(act_q, beat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= CFG_RESET;
      base_q  <= '0;
      beat_q  <= '0;
      lat_q   <= '0;
    end else if (ce_n) begin
      state_q <= ST_IDLE;
    end else if (start_w) begin
      state_q <= ST_LAT;
      act_q   <= cfg;
      base_q  <= addr_in;
      beat_q  <= '0;
      lat_q   <= cfg.lat - LAT_W'(1);
    end else begin
      case (state_q)
        ST_LAT: begin
          lat_q <= lat_q - LAT_W'(1);
          if (lat_q == LAT_W'(1)) state_q <= ST_BURST;
        end
        ST_BURST: begin
          if (last_w) state_q <= ST_IDLE;
          else        beat_q  <= beat_q + BEAT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbr_out.sv
module lbr_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          eob_now,
  input  logic [DW-1:0] data_in,
  input  logic          oe_n,
  input  logic          ce_n,
  input  logic          sync,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          dvalid,
  output logic          eob_n,
  output logic          eob_oe
);

  logic eob_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvalid <= 1'b0;
      eob_q  <= 1'b0;
      dq_out <= '0;
    end else begin
      dvalid <= fire;
      eob_q  <= fire && eob_now;
      if (fire) dq_out <= data_in;
    end
  end

  assign dq_oe  = dvalid && !oe_n && !ce_n;
  assign eob_oe = !oe_n && !ce_n && sync;
  assign eob_n  = !eob_q;

endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          dvalid,
  output logic          eob_n,
  output logic          eob_oe
);

  lbr_cfg_t cfg_q;
  logic     fire_w;
  logic     eob_now_w;

  lbr_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  lbr_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .ce_n     (ce_n),
    .adv_n    (adv_n),
    .addr_in  (addr_in),
    .arr_addr (arr_addr),
    .fire     (fire_w),
    .eob_now  (eob_now_w)
  );

  lbr_out #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire_w),
    .eob_now (eob_now_w),
    .data_in (data_in),
    .oe_n    (oe_n),
    .ce_n    (ce_n),
    .sync    (cfg_q.sync),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .dvalid  (dvalid),
    .eob_n   (eob_n),
    .eob_oe  (eob_oe)
  );

endmodule

// File: rtl/lbr_chk.sv
module lbr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       adv_n,
  input logic       oe_n,
  input logic       cfg_we,
  input logic [2:0] cfg_wlat,
  input logic [7:0] cfg_q,
  input logic       fire,
  input logic       dvalid,
  input logic       dq_oe,
  input logic       eob_n,
  input logic       eob_oe
);

  // R5
  fire_to_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dvalid);

  // R7
  ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dvalid);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n && cfg_q[0]) |=> !dvalid);

  // R2
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wlat < 3'd2) |=> $stable(cfg_q));

  // R6
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && !eob_oe));

  // R9, R10
  eob_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eob_n |=> eob_n);

  // R12
  eob_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eob_n |-> dvalid);

endmodule

bind lbr_ctrl lbr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .adv_n    (adv_n),
  .oe_n     (oe_n),
  .cfg_we   (cfg_we),
  .cfg_wlat (cfg_wdata[3:1]),
  .cfg_q    (cfg_q),
  .fire     (fire_w),
  .dvalid   (dvalid),
  .dq_oe    (dq_oe),
  .eob_n    (eob_n),
  .eob_oe   (eob_oe)
);

// File: tb/sim_lbr_ctrl.sv
module sim_lbr_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] KEY = 16'h5A3C;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, cfg_we = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] data_in, dq_out;
  logic          dq_oe, dvalid, eob_n, eob_oe;

  always #10 clk = ~clk;

  assign data_in = arr_addr ^ KEY;   // array model

  lbr_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr_in(addr_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .arr_addr(arr_addr), .data_in(data_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .dvalid(dvalid), .eob_n(eob_n), .eob_oe(eob_oe)
  );

  typedef struct {logic [DW-1:0] d; logic eob; int idx;} item_t;
  item_t sbq[$];
  item_t it;
  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mkcfg(input bit sy, input int lat, input bit l8, input logic [2:0] sel);
    return {sel, l8, 3'(lat), sy};
  endfunction

  function automatic bit exp_eob(input logic [2:0] sel, input int n, input int i);
    if (sel == 3'b001) return i == n - 1;
    if (sel == 3'b011) return i == n - 2;
    return 1'b0;
  endfunction

  // monitor: compares every presented beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && dvalid) begin
      if (sbq.size() == 0) begin
        check("R5", "unexpected beat", 1, 0);
      end else begin
        it = sbq.pop_front();
        check("R5", $sformatf("data beat %0d", it.idx), 32'(dq_out), 32'(it.d));
        check("R9/R10/R11", $sformatf("eob_n beat %0d", it.idx), 32'(eob_n), 32'(!it.eob));
        if (oe_n) begin
          check("R6", "dq_oe while oe_n high", 32'(dq_oe), 0);
          check("R6", "eob_oe while oe_n high", 32'(eob_oe), 0);
        end else if (!ce_n) begin
          check("R6", "dq_oe while oe_n low", 32'(dq_oe), 1);
          check("R12", "eob_oe driven", 32'(eob_oe), 1);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic cfg_write(input logic [7:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start(input logic [AW-1:0] a);
    adv_n = 1'b0; addr_in = a;
    step();
    adv_n = 1'b1;
  endtask

  task automatic push_burst(input logic [AW-1:0] a, input int n, input logic [2:0] sel, input int upto);
    for (int i = 0; i < upto; i++) begin
      item_t x;
      x.d = (a + AW'(i)) ^ KEY; x.eob = exp_eob(sel, n, i); x.idx = i;
      sbq.push_back(x);
    end
  endtask

  task automatic expect_latency(input string req, input int lat);
    int j = 0;
    while (!dvalid && j < 20) begin step(); j++; end
    check(req, "latency", 32'(j), 32'(lat));
  endtask

  task automatic drain();
    int g = 0;
    while (sbq.size() != 0 && g < 40) begin step(); g++; end
    check("R5", "queue drained", 32'(sbq.size()), 0);
    step();
    check("R5", "dvalid low after burst", 32'(dvalid), 0);
  endtask

  task automatic run(input logic [AW-1:0] a, input int lat, input bit l8, input logic [2:0] sel);
    int n = l8 ? 8 : 4;
    push_burst(a, n, sel, n);
    start(a);
    expect_latency("R4", lat);
    drain();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    check("R1", "dvalid in reset", 32'(dvalid), 0);
    check("R1", "dq_oe in reset", 32'(dq_oe), 0);
    check("R1", "eob_oe in reset", 32'(eob_oe), 0);
    rst_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    step();

    // R3 default async mode: strobe starts nothing
    start(16'h0100);
    for (int i = 0; i < 12; i++) begin
      if (dvalid) check("R3", "beat in async mode", 1, 0);
      step();
    end
    check("R3", "dvalid async", 32'(dvalid), 0);
    check("R12", "eob_oe with sync off", 32'(eob_oe), 0);

    // R4 R5 R9 latency 3, four beats, marker on last
    cfg_write(mkcfg(1, 3, 0, 3'b001));
    check("R12", "eob_oe idle driven", 32'(eob_oe), 1);
    check("R12", "eob_n idle high", 32'(eob_n), 1);
    run(16'h0010, 3, 0, 3'b001);

    // R10 latency 2, eight beats, marker on second-to-last, address carry
    cfg_write(mkcfg(1, 2, 1, 3'b011));
    run(16'h00FC, 2, 1, 3'b011);

    // R11 other codes leave marker high
    cfg_write(mkcfg(1, 7, 0, 3'b000));
    run(16'h1230, 7, 0, 3'b000);
    cfg_write(mkcfg(1, 5, 0, 3'b101));
    run(16'h2000, 5, 0, 3'b101);

    // R2 writes with latency 1 and 0 are rejected; previous setup stays
    cfg_write(mkcfg(1, 1, 1, 3'b011));
    cfg_write(mkcfg(0, 0, 1, 3'b001));
    push_burst(16'h3000, 4, 3'b101, 4);
    start(16'h3000);
    expect_latency("R2", 5);
    drain();

    // R6 OE high floats outputs while burst advances
    cfg_write(mkcfg(1, 4, 1, 3'b001));
    push_burst(16'h4000, 8, 3'b001, 8);
    start(16'h4000);
    expect_latency("R4", 4);
    step();
    oe_n = 1'b1;
    #1 check("R6", "dq_oe floats at once", 32'(dq_oe), 0);
    repeat (3) step();
    check("R6", "burst continues", 32'(dvalid), 1);
    check("R6", "beats consumed while floating", 32'(sbq.size()), 3);
    oe_n = 1'b0;
    drain();

    // R7 CE abort after two beats
    cfg_write(mkcfg(1, 3, 0, 3'b001));
    push_burst(16'h5000, 4, 3'b001, 2);
    start(16'h5000);
    expect_latency("R4", 3);
    step();
    ce_n = 1'b1;
    #1 check("R7", "dq_oe off at abort", 32'(dq_oe), 0);
    step();
    check("R7", "dvalid after abort", 32'(dvalid), 0);
    ce_n = 1'b0;
    repeat (4) step();
    check("R7", "no resume", 32'(dvalid), 0);
    check("R7", "queue consumed", 32'(sbq.size()), 0);

    // R8 restart by new strobe
    push_burst(16'h6000, 4, 3'b001, 2);
    start(16'h6000);
    expect_latency("R4", 3);
    step();
    push_burst(16'h7700, 4, 3'b001, 4);
    start(16'h7700);
    check("R8", "dvalid cleared on restart", 32'(dvalid), 0);
    expect_latency("R8", 3);
    drain();

    // R1 asynchronous reset mid-burst returns default configuration
    cfg_write(mkcfg(1, 3, 1, 3'b001));
    push_burst(16'h8000, 8, 3'b001, 2);
    start(16'h8000);
    expect_latency("R4", 3);
    step();
    rst_n = 1'b0;
    #1;
    check("R1", "dvalid at reset", 32'(dvalid), 0);
    check("R1", "dq_oe at reset", 32'(dq_oe), 0);
    sbq.delete();
    step();
    rst_n = 1'b1;
    step();
    start(16'h9000);
    for (int i = 0; i < 10; i++) begin
      if (dvalid) check("R1", "burst after reset with default cfg", 1, 0);
      step();
    end
    check("R1", "default sync off", 32'(eob_oe), 0);

    report();
  end

endmodule